// File: doc/BRIEF.md
# Two-Level Reed-Solomon Track Encoder

This block protects a byte stream for helical-track recording with two concatenated Reed-Solomon codes. User bytes are taken in groups of 128. An outer detection code computes two check bytes over the whole group. The group and its outer check bytes are then split into two halves of 65 bytes. An inner correcting code adds four check bytes to each half. Each group of 128 bytes therefore leaves the block as two 69-byte code words, 138 bytes in total.

The two codes use different finite fields and different generator roots. Both encoders are systematic, so user bytes pass straight through and the check bytes follow them. Input and output each use a valid/ready byte handshake. While a user byte is on its way, the input handshake is tied to the output handshake. While check bytes are being emitted, the input is held off. A marker flags the first byte of every code word. Decoding, interleave storage and modulation are handled elsewhere.

Top module: `rs_track_enc`

## Requirements
- R1: After synchronous reset all check registers are zero, the frame position is the first byte of a code word (`out_sow` = 1), `out_valid` equals `in_valid`, and `in_ready` equals `out_ready`.
- R2: The two outer check bytes are the remainder of the 128 user bytes (first byte = highest-degree coefficient) times x^2, divided by (x+a^24)(x+a^25) over GF(256) with field polynomial x^8+x^4+x^3+x^2+1 (0x11D), a = x. The highest-degree remainder byte is emitted first, at output positions 132 and 133 of the group.
- R3: Each inner code word ends with four check bytes. They are the remainder of its 65 leading bytes times x^4, divided by (x+1)(x+a)(x+a^2)(x+a^3) over GF(256) with field polynomial x^8+x^5+x^3+x+1 (0x12B). The highest-degree byte comes first.
- R4: Each group is framed as follows. Positions 0..64 carry user bytes 0..64, then come four inner check bytes. Positions 69..131 carry user bytes 65..127, then the two outer check bytes, then four inner check bytes. Exactly 128 input bytes are consumed per 138 output bytes.
- R5: `out_sow` is 1 exactly when the current output position is 0 or 69 of a group.
- R6: `in_ready` is 0 whenever a check byte is being presented. An input byte is accepted only in the same cycle as an output transfer.
- R7: While a check byte is presented with `out_ready` low, `out_valid` stays 1 and `out_data` holds its value into the next cycle.
- R8: Back-to-back groups are encoded independently. No remainder from one group affects the next.
- R9: In user-byte positions `out_data` equals `in_data` unchanged, and `out_valid` follows `in_valid`.
- R10: A reset in the middle of a group discards it. The next group is encoded as if from power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | User byte |
| in_valid | input | 1 | User byte present |
| in_ready | output | 1 | User byte accepted this cycle when valid |
| out_data | output | 8 | Encoded byte |
| out_valid | output | 1 | Encoded byte present |
| out_ready | input | 1 | Sink accepts encoded byte |
| out_sow | output | 1 | Current output byte starts a code word |

## Verification
Several groups target specific failure modes.
- An impulse in the final user byte gives a non-zero result only in the check bytes. A swapped field polynomial, a wrong generator root or a reversed check-byte order shows up there directly.
- An impulse in the first user byte exercises the longest division path.
- Gaps in `in_valid` and pulses in `out_ready` that land on check bytes expose an encoder that lets input through during parity emission, drops a byte, or changes a stalled check byte.
- Groups run back to back, and one group is cut short by reset. A design that kept a stale remainder, or mis-wrapped its position counter, would corrupt the group that follows.

// File: rtl/rs_pkg.sv
package rs_pkg;

   localparam int BW = 8;

   // multiply two field elements, reduction by the low 8 bits of the field polynomial
   function automatic logic [BW-1:0] gf_mul(input logic [BW-1:0] a,
                                            input logic [BW-1:0] b,
                                            input logic [BW-1:0] plow);
      logic [BW-1:0] acc;
      logic [BW-1:0] sh;
      acc = '0;
      sh  = a;
      for (int i = 0; i < BW; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = {sh[BW-2:0], 1'b0} ^ (sh[BW-1] ? plow : '0);
      end
      return acc;
   endfunction

   // alpha (= x) raised to e
   function automatic logic [BW-1:0] gf_pow(input int e, input logic [BW-1:0] plow);
      logic [BW-1:0] r;
      r = 8'h01;
      for (int i = 0; i < 255; i++)
         if (i < (e % 255)) r = gf_mul(r, 8'h02, plow);
      return r;
   endfunction

   // coefficient idx of prod_{k<n} (x + alpha^(first+k)), n <= 8
   function automatic logic [BW-1:0] gen_coef(input logic [BW-1:0] plow, input int first,
                                              input int n, input int idx);
      logic [BW-1:0] g [0:8];
      logic [BW-1:0] root;
      for (int j = 0; j <= 8; j++) g[j] = '0;
      g[0] = 8'h01;
      for (int k = 0; k < 8; k++) begin
         if (k < n) begin
            root = gf_pow(first + k, plow);
            for (int j = 8; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root, plow);
            g[0] = gf_mul(g[0], root, plow);
         end
      end
      return g[idx];
   endfunction

endpackage

// File: rtl/rs_par_lfsr.sv
module rs_par_lfsr #(
   parameter int         NPAR       = 4,
   parameter logic [8:0] POLY       = 9'h12B,
   parameter int         FIRST_ROOT = 0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 feed,
   input  logic                 shift,
   input  logic [rs_pkg::BW-1:0] din,
   output logic [rs_pkg::BW-1:0] par_top
);
   import rs_pkg::*;

   localparam logic [BW-1:0] PLOW = POLY[BW-1:0];

   if (NPAR < 1 || NPAR > 8) begin : g_bad_npar
      $error("rs_par_lfsr: NPAR must lie in 1..8");
   end
   if (POLY[8] != 1'b1) begin : g_bad_poly
      $error("rs_par_lfsr: field polynomial must have degree 8");
   end

   logic [BW-1:0] pr [NPAR];
   logic [BW-1:0] fb;

   assign fb      = din ^ pr[NPAR-1];
   assign par_top = pr[NPAR-1];

   for (genvar i = 0; i < NPAR; i++) begin : g_stage
      localparam logic [BW-1:0] GC = gen_coef(PLOW, FIRST_ROOT, NPAR, i);
      logic [BW-1:0] below;
      if (i == 0) begin : g_low
         assign below = '0;
      end else begin : g_up
         assign below = pr[i-1];
      end
      always_ff @(posedge clk) begin
         if (rst)        pr[i] <= '0;
         else if (feed)  pr[i] <= below ^ gf_mul(fb, GC, PLOW);
         else if (shift) pr[i] <= below;
      end
   end

   // sequencer never divides and drains in the same cycle
   assert_feed_shift_excl_R3: assert property (@(posedge clk) disable iff (rst)
      !(feed && shift));

endmodule

// File: rtl/rs_track_seq.sv
module rs_track_seq #(
   parameter int GROUP_LEN  = 128,
   parameter int SPLIT      = 65,
   parameter int OUTER_NPAR = 2,
   parameter int INNER_NPAR = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   output logic is_data,
   output logic is_outer,
   output logic is_inner,
   output logic sow
);
   localparam int TOTAL = GROUP_LEN + OUTER_NPAR + 2 * INNER_NPAR;
   localparam int PW    = $clog2(TOTAL);
   localparam logic [PW-1:0] P_IP1  = PW'(SPLIT);
   localparam logic [PW-1:0] P_W2   = PW'(SPLIT + INNER_NPAR);
   localparam logic [PW-1:0] P_OP   = PW'(GROUP_LEN + INNER_NPAR);
   localparam logic [PW-1:0] P_IP2  = PW'(GROUP_LEN + INNER_NPAR + OUTER_NPAR);
   localparam logic [PW-1:0] P_LAST = PW'(TOTAL - 1);

   if (SPLIT < 1 || SPLIT >= GROUP_LEN) begin : g_bad_split
      $error("rs_track_seq: SPLIT must fall inside the group");
   end
   if (SPLIT + INNER_NPAR > 255 || GROUP_LEN - SPLIT + OUTER_NPAR + INNER_NPAR > 255) begin : g_bad_len
      $error("rs_track_seq: inner code word longer than the field allows");
   end
   if (GROUP_LEN + OUTER_NPAR > 255) begin : g_bad_outer
      $error("rs_track_seq: outer code word longer than the field allows");
   end

   logic [PW-1:0] pos;

   always_ff @(posedge clk) begin
      if (rst)      pos <= '0;
      else if (adv) pos <= (pos == P_LAST) ? '0 : pos + 1'b1;
   end

   always_comb begin
      is_data  = (pos < P_IP1) || (pos >= P_W2 && pos < P_OP);
      is_outer = (pos >= P_OP) && (pos < P_IP2);
      is_inner = !is_data && !is_outer;
      sow      = (pos == '0) || (pos == P_W2);
   end

   assert_pos_range_R4: assert property (@(posedge clk) disable iff (rst)
      pos <= P_LAST);
   assert_group_wrap_R4: assert property (@(posedge clk) disable iff (rst)
      (adv && pos == P_LAST) |=> sow);
   assert_one_phase_R4: assert property (@(posedge clk) disable iff (rst)
      $onehot({is_data, is_outer, is_inner}));

endmodule

// File: rtl/rs_track_enc.sv
module rs_track_enc #(
   parameter int         GROUP_LEN   = 128,
   parameter int         SPLIT       = 65,
   parameter int         OUTER_NPAR  = 2,
   parameter int         INNER_NPAR  = 4,
   parameter logic [8:0] OUTER_POLY  = 9'h11D,
   parameter logic [8:0] INNER_POLY  = 9'h12B,
   parameter int         OUTER_ROOT0 = 24,
   parameter int         INNER_ROOT0 = 0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [7:0] in_data,
   input  logic       in_valid,
   output logic       in_ready,
   output logic [7:0] out_data,
   output logic       out_valid,
   input  logic       out_ready,
   output logic       out_sow
);
   logic       is_data, is_outer, is_inner;
   logic       xfer;
   logic [7:0] outer_top, inner_top, inner_din;

   rs_track_seq #(
      .GROUP_LEN(GROUP_LEN), .SPLIT(SPLIT),
      .OUTER_NPAR(OUTER_NPAR), .INNER_NPAR(INNER_NPAR)
   ) u_seq (
      .clk(clk), .rst(rst), .adv(xfer),
      .is_data(is_data), .is_outer(is_outer), .is_inner(is_inner), .sow(out_sow)
   );

   always_comb begin
      out_valid = is_data ? in_valid : 1'b1;
      in_ready  = is_data && out_ready;
      xfer      = out_valid && out_ready;
      if (is_data)       out_data = in_data;
      else if (is_outer) out_data = outer_top;
      else               out_data = inner_top;
      inner_din = is_data ? in_data : outer_top;
   end

   rs_par_lfsr #(.NPAR(OUTER_NPAR), .POLY(OUTER_POLY), .FIRST_ROOT(OUTER_ROOT0)) u_outer (
      .clk(clk), .rst(rst),
      .feed(xfer && is_data), .shift(xfer && is_outer),
      .din(in_data), .par_top(outer_top)
   );

   rs_par_lfsr #(.NPAR(INNER_NPAR), .POLY(INNER_POLY), .FIRST_ROOT(INNER_ROOT0)) u_inner (
      .clk(clk), .rst(rst),
      .feed(xfer && (is_data || is_outer)), .shift(xfer && is_inner),
      .din(inner_din), .par_top(inner_top)
   );

   assert_in_with_out_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |-> (out_valid && out_ready));
   assert_no_take_in_check_R6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !is_data) |-> !in_ready);
   assert_check_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready && !is_data) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/tb_rs_track_enc.sv
`timescale 1ns/1ps
module tb_rs_track_enc;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] in_data = '0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] out_data;
   logic       out_valid;
   logic       out_ready = 1'b0;
   logic       out_sow;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   rs_track_enc dut (
      .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready), .out_sow(out_sow)
   );

   // stimulus table: {kind[15:12], seed[11:4], backpressure[3:0]}
   // kind 0 zero, 1 all ones, 2 ramp, 3 pseudo-random, 4 impulse at byte seed
   // backpressure bit0: out_ready pulses low, bit1: in_valid gaps
   localparam logic [15:0] VEC [0:6] = '{
      {4'd0, 8'h00, 4'd0},
      {4'd2, 8'h00, 4'd1},
      {4'd3, 8'h5A, 4'd2},
      {4'd1, 8'h00, 4'd3},
      {4'd4, 8'd127, 4'd0},
      {4'd3, 8'hC3, 4'd3},
      {4'd4, 8'd0, 4'd1}
   };

   logic [7:0] dat  [0:127];
   logic [7:0] msg  [0:135];
   logic [7:0] remv [0:3];
   logic [7:0] expv [0:137];

   task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b, input logic [7:0] p);
      logic [7:0] r = '0;
      logic [7:0] x = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) r ^= x;
         x = x[7] ? ((x << 1) ^ p) : (x << 1);
      end
      return r;
   endfunction

   // long division of msg[0..len-1] * x^n by the generator; remainder in remv, top degree first
   task automatic m_rem(input logic [7:0] p, input int first, input int n, input int len);
      logic [7:0] g [0:4];
      logic [7:0] w [0:139];
      logic [7:0] root;
      logic [7:0] c;
      for (int j = 0; j <= 4; j++) g[j] = '0;
      g[0] = 8'h01;
      for (int k = 0; k < n; k++) begin
         root = 8'h01;
         for (int e = 0; e < first + k; e++) root = m_mul(root, 8'h02, p);
         for (int j = 4; j >= 1; j--) g[j] = g[j-1] ^ m_mul(g[j], root, p);
         g[0] = m_mul(g[0], root, p);
      end
      for (int i = 0; i < 140; i++) w[i] = (i < len) ? msg[i] : 8'h00;
      for (int i = 0; i < len; i++) begin
         c = w[i];
         for (int j = 1; j <= n; j++) w[i+j] ^= m_mul(c, g[n-j], p);
      end
      for (int j = 0; j < 4; j++) remv[j] = (j < n) ? w[len+j] : 8'h00;
   endtask

   task automatic build(input logic [3:0] kind, input logic [7:0] seed);
      logic [7:0] x;
      logic [7:0] op0, op1;
      x = (seed == 0) ? 8'h01 : seed;
      for (int i = 0; i < 128; i++) begin
         case (kind)
            4'd0: dat[i] = 8'h00;
            4'd1: dat[i] = 8'hFF;
            4'd2: dat[i] = 8'(i * 3 + 1);
            4'd3: begin dat[i] = x; x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1); end
            default: dat[i] = (i == int'(seed)) ? 8'h01 : 8'h00;
         endcase
      end
      for (int i = 0; i < 128; i++) msg[i] = dat[i];
      m_rem(8'h1D, 24, 2, 128);
      op0 = remv[0]; op1 = remv[1];
      for (int i = 0; i < 65; i++) begin msg[i] = dat[i]; expv[i] = dat[i]; end
      m_rem(8'h2B, 0, 4, 65);
      for (int j = 0; j < 4; j++) expv[65+j] = remv[j];
      for (int i = 0; i < 63; i++) begin msg[i] = dat[65+i]; expv[69+i] = dat[65+i]; end
      msg[63] = op0; msg[64] = op1;
      expv[132] = op0; expv[133] = op1;
      m_rem(8'h2B, 0, 4, 65);
      for (int j = 0; j < 4; j++) expv[134+j] = remv[j];
   endtask

   function automatic string tag_of(input int oc);
      if (oc < 65 || (oc >= 69 && oc < 132)) return "R9 data byte";
      if (oc == 132 || oc == 133) return "R2 outer check";
      return "R3 inner check";
   endfunction

   // runs one group; stops early after max_out output bytes
   task automatic run_group(input logic [3:0] bp, input int max_out, input string grp);
      int ic = 0;
      int oc = 0;
      int cyc = 0;
      bit prev_stall = 0;
      logic [7:0] prev_d = '0;
      bit chk_pos;
      while (oc < max_out && oc < 138) begin
         @(negedge clk);
         cyc++;
         out_ready = bp[0] ? (cyc % 3 != 1) : 1'b1;
         in_valid  = (ic < 128) && (bp[1] ? (cyc % 4 != 2) : 1'b1);
         in_data   = dat[(ic < 128) ? ic : 0];
         #1;
         chk_pos = !((oc < 65) || (oc >= 69 && oc < 132));
         if (prev_stall)
            chk(out_valid && out_data == prev_d, {"R7 held check byte ", grp}, out_data, prev_d);
         prev_stall = chk_pos && out_valid && !out_ready;
         prev_d     = out_data;
         if (chk_pos)
            chk(!in_ready, {"R6 input held during check ", grp}, {7'd0, in_ready}, 8'd0);
         else
            chk(out_valid == in_valid, {"R9 valid follows input ", grp}, {7'd0, out_valid}, {7'd0, in_valid});
         if (out_valid && out_ready) begin
            chk(out_data == expv[oc], {tag_of(oc), " ", grp}, out_data, expv[oc]);
            chk(out_sow == (oc == 0 || oc == 69), {"R5 start marker ", grp}, {7'd0, out_sow},
                {7'd0, (oc == 0 || oc == 69)});
            if (!chk_pos) begin
               chk(in_valid && in_ready, {"R6 input taken with output ", grp}, {7'd0, in_ready}, 8'd1);
               ic++;
            end
            oc++;
         end else begin
            chk(!(in_valid && in_ready), {"R6 input taken without output ", grp}, {7'd0, in_ready}, 8'd0);
         end
      end
      @(negedge clk);
      in_valid  = 1'b0;
      out_ready = 1'b0;
      if (oc == 138)
         chk(ic == 128, {"R4 bytes consumed per group ", grp}, 8'(ic), 8'd128);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      out_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      do_reset();
      // R1: reset state at the ports
      @(negedge clk);
      out_ready = 1'b1;
      in_valid  = 1'b0;
      #1;
      chk(out_sow == 1'b1, "R1 marker after reset", {7'd0, out_sow}, 8'd1);
      chk(out_valid == 1'b0, "R1 valid follows input after reset", {7'd0, out_valid}, 8'd0);
      chk(in_ready == 1'b1, "R1 ready follows sink after reset", {7'd0, in_ready}, 8'd1);
      out_ready = 1'b0;
      #1;
      chk(in_ready == 1'b0, "R1 ready follows sink low", {7'd0, in_ready}, 8'd0);

      // R8: table walked back to back without reset
      for (int v = 0; v < 7; v++) begin
         build(VEC[v][15:12], VEC[v][11:4]);
         run_group(VEC[v][3:0], 138, $sformatf("R8 vec%0d", v));
      end

      // R10: abort a group part way into its first inner check bytes, then a fresh group
      build(4'd3, 8'h77);
      run_group(4'd0, 67, "R10 partial");
      do_reset();
      build(4'd3, 8'h9E);
      run_group(4'd1, 138, "R10 after reset");

      // R1: impulse right after reset, clean start of the division
      do_reset();
      build(4'd4, 8'd64);
      run_group(4'd2, 138, "R1 first group");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule